// File: doc/BRIEF.md
# Selectable Adder/Encoder Unit

This combinational block shares one 4-bit input bus between two small functions and returns a 2-bit result. A one-bit mode input chooses which function drives the result. In adder mode the three low input bits are added as a single-bit full addition, and the top bit plays no part. In encoder mode all four input bits are read as one-hot request lines, and the result is the binary index of the line that is high.

The block has no clock and no reset. The result follows the inputs directly. It is meant to sit inside a wider datapath wherever a tiny add-or-locate step is needed behind a single select wire.

Top module: `addenc_unit`

## Requirements
- R1: `mode_sel` = 0 routes the adder result to `res`; `mode_sel` = 1 routes the encoder result to `res`.
- R2: In adder mode, `din[3]` has no effect: `res` is identical for any two inputs that differ only in bit 3.
- R3: In adder mode, `res[1]` is the sum bit, which is the XOR of `din[2]`, `din[1]` and `din[0]`. Bit 0 acts as carry-in.
- R4: In adder mode, `res[0]` is the carry-out, which is high when at least two of `din[2:0]` are high.
- R5: In encoder mode, the one-hot inputs map as follows: `din` = 0001 gives `res` = 00, 0010 gives 01, 0100 gives 10, and 1000 gives 11.
- R6: In encoder mode, any `din` that is not one-hot gives `res` = 00. This includes 0000 and every value with more than one bit set.
- R7: `res` settles to its new value after a change of `din` or `mode_sel` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 4 | Shared operand / request bus |
| mode_sel | input | 1 | 0 selects the adder, 1 selects the encoder |
| res | output | 2 | Adder {sum, carry} or encoder index |

## Verification
Immediate assertions are re-evaluated on every input change. In adder mode they check the sum and carry against a count of set bits. In encoder mode they check that the index decodes back to the one-hot input, and that a non-one-hot input returns zero. Other properties only the bench's scenarios can show: that bit 3 is ignored, which is a comparison between two different input values, and that the result changes without any clock edge. The bench sweeps all 16 input values under both select settings and compares each result with arithmetic computed in the bench.

// File: rtl/addenc_pkg.sv
package addenc_pkg;

    localparam int DIN_W  = 4;
    localparam int IDX_W  = $clog2(DIN_W);
    localparam int RES_W  = 2;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_ENC = 1'b1
    } mode_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    function automatic logic is_onehot(input logic [DIN_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic int unsigned ones3(input logic [2:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]);
    endfunction

endpackage

// File: rtl/addenc_fa.sv
module addenc_fa
    import addenc_pkg::*;
(
    input  logic    op_a,
    input  logic    op_b,
    input  logic    cin,
    output fa_res_t out
);

    logic half_s;

    always_comb begin
        half_s    = op_a ^ op_b;
        out.sum   = half_s ^ cin;
        out.carry = (op_a & op_b) | (half_s & cin);
    end

    // Arithmetic cross-check of the gate-level add.
    always_comb begin
        AST_FA_ARITH: assert ({out.carry, out.sum} ==
                              (2'(op_a) + 2'(op_b) + 2'(cin))); // R3
    end

endmodule

// File: rtl/addenc_enc.sv
module addenc_enc
    import addenc_pkg::*;
#(
    parameter int WIDTH = DIN_W,
    localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] lines,
    output logic [IW-1:0]    idx
);

    logic            valid;
    logic [IW-1:0]   raw;

    assign valid = (lines != '0) && ((lines & (lines - 1'b1)) == '0);

    for (genvar b = 0; b < IW; b++) begin : g_idx_bit
        always_comb begin
            raw[b] = 1'b0;
            for (int i = 0; i < WIDTH; i++) begin
                if (((i >> b) & 1) == 1 && lines[i]) raw[b] = 1'b1;
            end
        end
    end

    assign idx = valid ? raw : '0;

    always_comb begin
        if (valid) begin
            AST_ENC_DECODE: assert ((WIDTH'(1) << idx) == lines); // R5
        end else begin
            AST_ENC_ZERO: assert (idx == '0); // R6
        end
    end

endmodule

// File: rtl/addenc_unit.sv
module addenc_unit
    import addenc_pkg::*;
(
    input  logic [3:0] din,
    input  logic       mode_sel,
    output logic [1:0] res
);

    fa_res_t          fa_out;
    logic [IDX_W-1:0] enc_idx;
    mode_e            mode;

    assign mode = mode_e'(mode_sel);

    addenc_fa u_fa (
        .op_a (din[2]),
        .op_b (din[1]),
        .cin  (din[0]),
        .out  (fa_out)
    );

    addenc_enc #(.WIDTH(DIN_W)) u_enc (
        .lines (din),
        .idx   (enc_idx)
    );

    always_comb begin
        unique case (mode)
            MODE_ADD: res = {fa_out.sum, fa_out.carry};
            MODE_ENC: res = RES_W'(enc_idx);
            default:  res = '0;
        endcase
    end

    always_comb begin
        if (mode == MODE_ADD) begin
            AST_ADD_SUM:   assert (res[1] == ((ones3(din[2:0]) % 2) == 1)); // R3
            AST_ADD_CARRY: assert (res[0] == (ones3(din[2:0]) >= 2));       // R4
        end else if (!is_onehot(din)) begin
            AST_ENC_IDLE:  assert (res == 2'b00);                           // R6
        end else begin
            AST_ENC_HIT:   assert (din[res] == 1'b1);                       // R5
        end
    end

endmodule

// File: tb/tb_addenc_unit.sv
module tb_addenc_unit;

    logic       clk = 1'b0;
    logic [3:0] din;
    logic       mode_sel;
    logic [1:0] res;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    addenc_unit dut (
        .din      (din),
        .mode_sel (mode_sel),
        .res      (res)
    );

    function automatic logic [1:0] model(input logic [3:0] v, input logic s);
        int n;
        if (!s) begin
            n = int'(v[0]) + int'(v[1]) + int'(v[2]);
            return {1'(n % 2), 1'(n / 2)};
        end
        case (v)
            4'b0001: return 2'd0;
            4'b0010: return 2'd1;
            4'b0100: return 2'd2;
            4'b1000: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s din=%b sel=%b got=%b exp=%b", tag, din, mode_sel, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] v, input logic s);
        @(negedge clk);
        din = v;
        mode_sel = s;
        #5;
    endtask

    initial begin
        logic [1:0] r_lo;
        din = '0;
        mode_sel = 1'b0;
        #5;
        check("R4 initial", res, 2'b00);

        // Full sweep, both modes
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 16; v++) begin
                apply(4'(v), 1'(s));
                if (s == 0)
                    check("R1 R3 R4 adder", res, model(4'(v), 1'b0));
                else if (v == 1 || v == 2 || v == 4 || v == 8)
                    check("R1 R5 encoder onehot", res, model(4'(v), 1'b1));
                else
                    check("R6 encoder non-onehot", res, 2'b00);
            end
        end

        // R2: bit 3 ignored in adder mode
        for (int v = 0; v < 8; v++) begin
            apply(4'(v), 1'b0);
            r_lo = res;
            apply(4'(v) | 4'b1000, 1'b0);
            check("R2 msb ignored", res, r_lo);
        end

        // R7: change without waiting for an edge
        @(posedge clk);
        #3;
        din = 4'b1000; mode_sel = 1'b1;
        #1;
        check("R7 settles", res, 2'b11);
        din = 4'b0111; mode_sel = 1'b0;
        #1;
        check("R7 settles", res, 2'b11);
        mode_sel = 1'b1;
        #1;
        check("R7 R1 switch", res, 2'b00);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule